// File: doc/BRIEF.md
# Programmable Logic Output Macrocell

This block is one output cell of a small programmable logic device. It receives the OR-ed sum-of-products term computed by the logic array for its output. It also receives a per-cell output-enable term and two terms shared by all cells: an asynchronous clear and a synchronous set. Two static configuration bits, loaded elsewhere, choose between a clocked (registered) path and a direct (combinatorial) path, and between true and inverted output polarity.

The cell drives a tri-state pin model, made of a data value and an enable, and returns one feedback bit to the logic array. In registered mode the feedback is the register's true state. In combinatorial mode the feedback is the pin value. That pin value is the cell's own drive when the enable term is high, and the externally applied `pin_in` when it is low. A power-on reset clears the register. The pin level after reset therefore depends on the chosen polarity.

Top module: `pld_out_cell`

## Requirements
- R1: With `cfg_comb`=1, `pin_out` equals `sum_term` when `cfg_true`=1 and its inverse when `cfg_true`=0, with no clock needed (encodings {cfg_comb,cfg_true}: 00 registered inverted, 01 registered true, 10 combinatorial inverted, 11 combinatorial true).
- R2: With `cfg_comb`=0, the register loads `sum_term` on each rising clock edge, and `pin_out` is the register state when `cfg_true`=1 and its inverse when `cfg_true`=0.
- R3: `pin_oe` follows `oe_term` in every configuration.
- R4: With `cfg_comb`=0, `fb_out` is the true register state, whatever the values of `oe_term` and `pin_in`.
- R5: With `cfg_comb`=1, `fb_out` equals `pin_out` while `oe_term`=1 and equals `pin_in` while `oe_term`=0.
- R6: `areset_term`=1 clears the register at once, without waiting for a clock edge.
- R7: `spreset_term`=1 sets the register to 1 at the next rising clock edge and not before, overriding `sum_term`.
- R8: When `areset_term` and `spreset_term` are both high at a clock edge, the register remains 0.
- R9: While `rst_n` is low the register is 0, so in registered mode `fb_out` reads 0 and `pin_out` reads 1 under inverted polarity and 0 under true polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| cfg_comb | input | 1 | 1 selects the combinatorial path, 0 the registered path |
| cfg_true | input | 1 | 1 drives true polarity, 0 drives inverted polarity |
| sum_term | input | 1 | Sum-of-products term from the array |
| oe_term | input | 1 | Output-enable product term for this cell |
| areset_term | input | 1 | Shared asynchronous clear term |
| spreset_term | input | 1 | Shared synchronous set term |
| pin_in | input | 1 | Level applied to the pin from outside |
| pin_out | output | 1 | Data value driven toward the pin |
| pin_oe | output | 1 | Pin driver enable |
| fb_out | output | 1 | Feedback bit returned to the array |

## Verification
The bench steps through all four configurations. For each one it sweeps every combination of sum term, enable term, external pin level and set term. This separates the polarity choice from the path choice. It also shows that, in combinatorial mode, the feedback switches between the driven value and the external level depending on the enable. In registered mode it shows that the feedback ignores both the enable and the external level. Outputs are checked both before and after each clock edge, so that a registered value leaking through early, or a combinatorial value that is mistakenly clocked, is caught. Separate sequences raise the clear term between edges, hold the set term up to an edge, and assert both terms across one edge, to check the ordering of clear and set.

// File: rtl/pld_out_cell.sv
module pld_out_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_comb,
  input  logic cfg_true,
  input  logic sum_term,
  input  logic oe_term,
  input  logic areset_term,
  input  logic spreset_term,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  output logic fb_out
);

  logic q;
  logic path;

  always_ff @(posedge clk or negedge rst_n or posedge areset_term) begin
    if (!rst_n || areset_term) q <= 1'b0;
    else if (spreset_term)     q <= 1'b1;
    else                       q <= sum_term;
  end

  assign path    = cfg_comb ? sum_term : q;
  assign pin_out = cfg_true ? path : ~path;
  assign pin_oe  = oe_term;
  assign fb_out  = cfg_comb ? (oe_term ? pin_out : pin_in) : q;

  AST_PRESET_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (spreset_term && !areset_term) |=> (q || areset_term)); // R7

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    areset_term |-> !q); // R8

  AST_REG_FB_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_comb && !areset_term && !spreset_term) |=>
      (cfg_comb || areset_term || fb_out == $past(sum_term))); // R4

  AST_COMB_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_comb && oe_term) |-> ((fb_out == sum_term) == cfg_true)); // R5

endmodule

// File: tb/pld_out_cell_tb.sv
module pld_out_cell_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_comb = 1'b0, cfg_true = 1'b0;
  logic sum_term = 1'b0, oe_term = 1'b0, areset_term = 1'b0, spreset_term = 1'b0, pin_in = 1'b0;
  logic pin_out, pin_oe, fb_out;
  int n_checks = 0;
  int n_fails = 0;
  logic exp_q = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pld_out_cell dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_comb(cfg_comb), .cfg_true(cfg_true),
    .sum_term(sum_term), .oe_term(oe_term), .areset_term(areset_term),
    .spreset_term(spreset_term), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .fb_out(fb_out)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_all(input string tag_path, input string tag_fb);
    logic core, po, fb;
    core = cfg_comb ? sum_term : exp_q;
    po   = cfg_true ? core : ~core;
    fb   = cfg_comb ? (oe_term ? po : pin_in) : exp_q;
    chk(tag_path, pin_out, po);
    chk("R3 pin_oe", pin_oe, oe_term);
    chk(tag_fb, fb_out, fb);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    // R9: reset state, registered inverted then registered true
    repeat (2) @(posedge clk);
    @(negedge clk);
    sum_term = 1'b1;
    #1;
    chk("R9 fb during reset", fb_out, 1'b0);
    chk("R9 inverted pin during reset", pin_out, 1'b1);
    cfg_true = 1'b1; #1;
    chk("R9 true pin during reset", pin_out, 1'b0);
    @(negedge clk);
    sum_term = 1'b0;
    cfg_true = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #1;
    exp_q = 1'b0;

    // R1 R2 R4 R5 R7: sweep every configuration and input pattern
    for (int cfg = 0; cfg < 4; cfg++) begin
      for (int v = 0; v < 16; v++) begin
        @(negedge clk);
        cfg_comb = cfg[1]; cfg_true = cfg[0];
        sum_term = v[0]; oe_term = v[1]; pin_in = v[2]; spreset_term = v[3];
        #1;
        if (cfg_comb) check_all("R1 comb pin", "R5 comb fb");
        else          check_all("R2 reg pin before edge", "R4 reg fb before edge");
        @(posedge clk); #1;
        exp_q = spreset_term ? 1'b1 : sum_term;
        if (cfg_comb) check_all("R1 comb pin after edge", "R5 comb fb after edge");
        else if (spreset_term) check_all("R7 preset pin", "R7 preset fb");
        else check_all("R2 reg pin after edge", "R4 reg fb after edge");
      end
    end

    // R7: set term is not seen before the edge
    @(negedge clk);
    cfg_comb = 1'b0; cfg_true = 1'b1; oe_term = 1'b1; spreset_term = 1'b0; sum_term = 1'b0;
    @(posedge clk); #1; exp_q = 1'b0;
    @(negedge clk); spreset_term = 1'b1; #1;
    chk("R7 no set before edge", fb_out, 1'b0);
    @(posedge clk); #1; exp_q = 1'b1;
    chk("R7 set at edge", fb_out, 1'b1);

    // R6: clear between edges acts at once
    @(negedge clk); spreset_term = 1'b0; sum_term = 1'b1;
    @(posedge clk); #1;
    chk("R6 loaded before clear", fb_out, 1'b1);
    #2; areset_term = 1'b1; #1;
    chk("R6 immediate clear fb", fb_out, 1'b0);
    chk("R6 immediate clear pin", pin_out, 1'b0);

    // R8: clear and set together across an edge
    @(negedge clk); spreset_term = 1'b1;
    @(posedge clk); #1;
    chk("R8 clear beats set", fb_out, 1'b0);
    @(negedge clk); areset_term = 1'b0; spreset_term = 1'b0; sum_term = 1'b0;
    @(posedge clk); #1;
    chk("R8 stays clear after release", fb_out, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule